// File: doc/BRIEF.md
# Pointer Masking Address Transformer

This block sits between address generation and the memory pipeline of a 64-bit core. It turns an effective address into the address a load or store really uses: a number of upper pointer bits are ignored, and the freed positions are refilled from the highest kept bit (sign fill) or with zeros (zero fill). This lets software keep tags in the top of its pointers without those tags reaching translation or memory.

How many bits are ignored comes from a 2-bit masking mode. For ordinary accesses the mode arrives already selected on its own input. For loads and stores that a hypervisor issues on behalf of a guest, the block picks the mode itself: from the guest-user field when the effective privilege is User, otherwise from the hypervisor or supervisor environment field according to the guest-previous-privilege bit. Ordinary accesses use sign fill exactly when address translation is on; guest accesses always use zero fill. In 32-bit operation the address is never changed. The result leaves through one registered stage with a valid flag.

Top module: `pm_addr_xform`

## Requirements
- R1: When `rv32_mode` is 1, `out_addr` equals the input address unchanged, whatever the mode fields and flags.
- R2: A selected mode of 0 (off) or 1 (reserved) leaves the address unchanged.
- R3: Selected mode 2 ignores the top 7 bits: bits 63..57 of the result are refilled and bits 56..0 are kept.
- R4: Selected mode 3 ignores the top 16 bits: bits 63..48 are refilled and bits 47..0 are kept.
- R5: For an ordinary access (`vm_access` = 0) the refill copies the highest kept bit when `xlat_on` is 1 and is zero when `xlat_on` is 0.
- R6: A guest access (`vm_access` = 1) always uses zero refill, whatever `xlat_on` is.
- R7: A guest access with `eff_priv` = 2'b00 (User) takes its mode from `gu_pmm`.
- R8: A guest access with `eff_priv` not User takes its mode from `henv_pmm` when `spvp` is 1 and from `senv_pmm` when `spvp` is 0.
- R9: An ordinary access takes its mode from `norm_pmm`; `gu_pmm`, `henv_pmm`, `senv_pmm` and `spvp` have no effect on it.
- R10: `out_valid` and `out_addr` appear exactly one clock after the matching `in_valid`/`in_addr`; `out_valid` is 0 one clock after `in_valid` is 0.
- R11: While `rst_n` is 0, `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | Input address is valid |
| in_addr | input | 64 | Effective address |
| rv32_mode | input | 1 | Core runs with 32-bit register width |
| vm_access | input | 1 | Hypervisor load/store on behalf of a guest |
| eff_priv | input | 2 | Effective privilege (00 User, 01 Supervisor, 11 Machine) |
| xlat_on | input | 1 | Address translation active for an ordinary access |
| norm_pmm | input | 2 | Preselected mode for ordinary accesses |
| gu_pmm | input | 2 | Guest-user mode field from hypervisor status |
| spvp | input | 1 | Guest-previous-privilege bit from hypervisor status |
| henv_pmm | input | 2 | Mode field from hypervisor environment config |
| senv_pmm | input | 2 | Mode field from supervisor environment config |
| out_valid | output | 1 | Output address is valid |
| out_addr | output | 64 | Masked address |

## Verification
The hardest situation to reach is the one where the three guest mode sources disagree, since a wrong pick only shows when the chosen mode differs from the others and the address carries both tag bits and a set boundary bit. The stimulus loads `gu_pmm`, `henv_pmm` and `senv_pmm` with three different modes, feeds an all-ones address with translation on, and walks privilege and `spvp`, so each source yields a distinct zero-filled result. Boundary addresses with only bit 56 or bit 47 set, and their inverses, are run for each mode and fill kind.

// File: rtl/pm_xform_pkg.sv
package pm_xform_pkg;
  typedef enum logic [1:0] {
    PMM_OFF    = 2'd0,
    PMM_RSVD   = 2'd1,
    PMM_IGN_LO = 2'd2,
    PMM_IGN_HI = 2'd3
  } pmm_e;

  typedef enum logic [1:0] {
    PRIV_U   = 2'd0,
    PRIV_S   = 2'd1,
    PRIV_RSV = 2'd2,
    PRIV_M   = 2'd3
  } priv_e;

  function automatic logic pmm_active(input pmm_e m);
    return (m == PMM_IGN_LO) || (m == PMM_IGN_HI);
  endfunction
endpackage

// File: rtl/pm_mode_sel.sv
module pm_mode_sel
  import pm_xform_pkg::*;
(
  input  logic       vm_access,
  input  logic [1:0] eff_priv,
  input  logic [1:0] norm_pmm,
  input  logic [1:0] gu_pmm,
  input  logic       spvp,
  input  logic [1:0] henv_pmm,
  input  logic [1:0] senv_pmm,
  output pmm_e       sel_pmm
);
  pmm_e guest_pmm;

  always_comb begin
    if (priv_e'(eff_priv) == PRIV_U) begin
      guest_pmm = pmm_e'(gu_pmm);
    end else if (spvp) begin
      guest_pmm = pmm_e'(henv_pmm);
    end else begin
      guest_pmm = pmm_e'(senv_pmm);
    end
  end

  always_comb begin
    sel_pmm = vm_access ? guest_pmm : pmm_e'(norm_pmm);
  end
endmodule

// File: rtl/pm_mask_ctl.sv
module pm_mask_ctl
  import pm_xform_pkg::*;
#(
  parameter int IGN_LO = 7,
  parameter int IGN_HI = 16,
  localparam int CNT_W = $clog2(IGN_HI + 1)
) (
  input  pmm_e             sel_pmm,
  input  logic             rv32_mode,
  input  logic             vm_access,
  input  logic             xlat_on,
  output logic             bypass,
  output logic             sext,
  output logic [CNT_W-1:0] ign_cnt
);
  always_comb begin
    bypass = rv32_mode || !pmm_active(sel_pmm);
    sext   = !vm_access && xlat_on;
    unique case (sel_pmm)
      PMM_IGN_LO: ign_cnt = CNT_W'(IGN_LO);
      PMM_IGN_HI: ign_cnt = CNT_W'(IGN_HI);
      default:    ign_cnt = '0;
    endcase
  end
endmodule

// File: rtl/pm_mask_shift.sv
module pm_mask_shift #(
  parameter int ADDR_W = 64,
  parameter int CNT_W  = 5
) (
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [CNT_W-1:0]  ign_cnt,
  input  logic              sext,
  input  logic              bypass,
  output logic [ADDR_W-1:0] addr_out
);
  int   keep_w;
  logic fill;

  always_comb begin
    keep_w = bypass ? ADDR_W : ADDR_W - int'(ign_cnt);
    fill   = sext & addr_in[keep_w - 1];
  end

  for (genvar b = 0; b < ADDR_W; b++) begin : g_bit
    assign addr_out[b] = (b < keep_w) ? addr_in[b] : fill;
  end
endmodule

// File: rtl/pm_addr_xform.sv
module pm_addr_xform
  import pm_xform_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int IGN_LO = 7,
  parameter int IGN_HI = 16,
  localparam int CNT_W = $clog2(IGN_HI + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic              rv32_mode,
  input  logic              vm_access,
  input  logic [1:0]        eff_priv,
  input  logic              xlat_on,
  input  logic [1:0]        norm_pmm,
  input  logic [1:0]        gu_pmm,
  input  logic              spvp,
  input  logic [1:0]        henv_pmm,
  input  logic [1:0]        senv_pmm,
  output logic              out_valid,
  output logic [ADDR_W-1:0] out_addr
);
  pmm_e              sel_pmm;
  logic              bypass;
  logic              sext;
  logic [CNT_W-1:0]  ign_cnt;
  logic [ADDR_W-1:0] masked;

  logic              valid_d, valid_q;
  logic [ADDR_W-1:0] addr_d, addr_q;
  logic              addr_en;

  pm_mode_sel u_sel (
    .vm_access(vm_access), .eff_priv(eff_priv), .norm_pmm(norm_pmm),
    .gu_pmm(gu_pmm), .spvp(spvp), .henv_pmm(henv_pmm),
    .senv_pmm(senv_pmm), .sel_pmm(sel_pmm)
  );

  pm_mask_ctl #(.IGN_LO(IGN_LO), .IGN_HI(IGN_HI)) u_ctl (
    .sel_pmm(sel_pmm), .rv32_mode(rv32_mode), .vm_access(vm_access),
    .xlat_on(xlat_on), .bypass(bypass), .sext(sext), .ign_cnt(ign_cnt)
  );

  pm_mask_shift #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_shift (
    .addr_in(in_addr), .ign_cnt(ign_cnt), .sext(sext),
    .bypass(bypass), .addr_out(masked)
  );

  // next state
  always_comb begin
    valid_d = in_valid;
    addr_en = in_valid;
    addr_d  = masked;
  end

  // registers: valid resets, data is clock-enabled only
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (addr_en) addr_q <= addr_d;
  end

  assign out_valid = valid_q;
  assign out_addr  = addr_q;

  // assertions
  always @(posedge clk) begin
    if (!rst_n) p_reset_clear_r11: assert (!out_valid);
  end

  p_valid_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_valid_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  p_rv32_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && rv32_mode) |=> (out_addr == $past(in_addr)));
  p_off_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !pmm_active(sel_pmm)) |=> (out_addr == $past(in_addr)));
  p_vm_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && vm_access && !rv32_mode && sel_pmm == PMM_IGN_HI)
      |=> (out_addr[ADDR_W-1 -: IGN_HI] == '0));
  p_sext_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !vm_access && xlat_on && !rv32_mode && sel_pmm == PMM_IGN_LO)
      |=> ($countones(out_addr[ADDR_W-1 -: IGN_LO+1]) == 0 ||
           $countones(out_addr[ADDR_W-1 -: IGN_LO+1]) == IGN_LO + 1));
  p_keep_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && sel_pmm == PMM_IGN_HI)
      |=> (out_addr[ADDR_W-IGN_HI-1:0] == $past(in_addr[ADDR_W-IGN_HI-1:0])));
endmodule

// File: tb/pm_addr_xform_test.sv
module pm_addr_xform_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [63:0] in_addr;
  logic        rv32_mode, vm_access, xlat_on, spvp;
  logic [1:0]  eff_priv, norm_pmm, gu_pmm, henv_pmm, senv_pmm;
  logic        out_valid;
  logic [63:0] out_addr;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  pm_addr_xform uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_addr(in_addr),
    .rv32_mode(rv32_mode), .vm_access(vm_access), .eff_priv(eff_priv),
    .xlat_on(xlat_on), .norm_pmm(norm_pmm), .gu_pmm(gu_pmm), .spvp(spvp),
    .henv_pmm(henv_pmm), .senv_pmm(senv_pmm),
    .out_valid(out_valid), .out_addr(out_addr)
  );

  function automatic logic [63:0] model(input logic [63:0] a,
                                        input logic [1:0] mode,
                                        input logic sx);
    int n;
    logic [63:0] r;
    if (mode < 2) return a;
    n = (mode == 2) ? 7 : 16;
    for (int i = 0; i < 64; i++)
      r[i] = (i < 64 - n) ? a[i] : (sx ? a[63 - n] : 1'b0);
    return r;
  endfunction

  task automatic check(input string tag, input logic [63:0] got,
                       input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic apply(input logic [63:0] a, input logic r32, input logic vm,
                       input logic [1:0] pr, input logic xl,
                       input logic [1:0] nm, input logic [1:0] gu,
                       input logic sp, input logic [1:0] he,
                       input logic [1:0] se);
    @(negedge clk);
    in_valid = 1'b1; in_addr = a; rv32_mode = r32; vm_access = vm;
    eff_priv = pr; xlat_on = xl; norm_pmm = nm; gu_pmm = gu; spvp = sp;
    henv_pmm = he; senv_pmm = se;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; in_valid = 1'b0; in_addr = '0; rv32_mode = 0;
    vm_access = 0; eff_priv = 0; xlat_on = 0; norm_pmm = 0; gu_pmm = 0;
    spvp = 0; henv_pmm = 0; senv_pmm = 0;
    repeat (3) @(negedge clk);
    check("R11 reset valid", 64'(out_valid), 64'd0);
    @(posedge clk); #1 rst_n = 1'b1;
  endtask

  task automatic t_latency();
    @(negedge clk);
    in_valid = 1'b1; in_addr = 64'h0000_1234_5678_9abc; norm_pmm = 2'd0;
    vm_access = 0; rv32_mode = 0;
    check("R10 no early valid", 64'(out_valid), 64'd0);
    @(negedge clk);
    in_valid = 1'b0;
    check("R10 valid after one", 64'(out_valid), 64'd1);
    check("R10 addr after one", out_addr, 64'h0000_1234_5678_9abc);
    @(negedge clk);
    check("R10 valid drops", 64'(out_valid), 64'd0);
  endtask

  task automatic t_rv32();
    apply(64'hFFFF_0000_1234_5678, 1, 0, 0, 1, 3, 3, 1, 3, 3);
    check("R1 rv32 ordinary", out_addr, 64'hFFFF_0000_1234_5678);
    apply(64'h8000_0000_0000_0001, 1, 1, 0, 0, 2, 3, 0, 2, 2);
    check("R1 rv32 guest", out_addr, 64'h8000_0000_0000_0001);
  endtask

  task automatic t_disabled();
    apply(64'hA5A5_5A5A_0F0F_F0F0, 0, 0, 1, 1, 0, 3, 1, 3, 3);
    check("R2 mode off", out_addr, 64'hA5A5_5A5A_0F0F_F0F0);
    apply(64'hA5A5_5A5A_0F0F_F0F0, 0, 0, 1, 0, 1, 3, 1, 3, 3);
    check("R2 mode reserved", out_addr, 64'hA5A5_5A5A_0F0F_F0F0);
  endtask

  task automatic t_boundaries();
    logic [63:0] pats [4];
    pats[0] = 64'h0100_0000_0000_0000;
    pats[1] = 64'hFE00_0000_0000_0042;
    pats[2] = 64'h0000_8000_0000_0000;
    pats[3] = 64'hFFFF_0000_0000_1234;
    for (int m = 2; m < 4; m++) begin
      for (int x = 0; x < 2; x++) begin
        for (int p = 0; p < 4; p++) begin
          apply(pats[p], 0, 0, 1, x[0], m[1:0], 0, 0, 0, 0);
          check(m == 2 ? "R3 R5 ign7 boundary" : "R4 R5 ign16 boundary",
                out_addr, model(pats[p], m[1:0], x[0]));
        end
      end
    end
  endtask

  task automatic t_vm_select();
    logic [63:0] ones = '1;
    apply(ones, 0, 1, 0, 1, 0, 3, 1, 2, 0);
    check("R7 R6 guest user", out_addr, model(ones, 3, 0));
    apply(ones, 0, 1, 1, 1, 0, 3, 1, 2, 0);
    check("R8 spvp1 henv", out_addr, model(ones, 2, 0));
    apply(ones, 0, 1, 1, 1, 0, 3, 0, 2, 0);
    check("R8 spvp0 senv", out_addr, ones);
    apply(ones, 0, 1, 3, 1, 0, 2, 0, 2, 3);
    check("R8 machine senv", out_addr, model(ones, 3, 0));
    apply(64'h0000_8000_0000_0000, 0, 1, 0, 1, 0, 3, 0, 0, 0);
    check("R6 guest zero fill", out_addr, 64'h0000_8000_0000_0000);
  endtask

  task automatic t_ordinary_src();
    apply(64'hFFFF_FFFF_FFFF_FFFF, 0, 0, 0, 0, 2, 3, 1, 3, 3);
    check("R9 norm selects", out_addr, model('1, 2, 0));
    apply(64'hFFFF_FFFF_FFFF_FFFF, 0, 0, 1, 0, 0, 3, 1, 3, 3);
    check("R9 guest fields ignored", out_addr, 64'hFFFF_FFFF_FFFF_FFFF);
  endtask

  initial begin
    t_reset();
    t_latency();
    t_rv32();
    t_disabled();
    t_boundaries();
    t_vm_select();
    t_ordinary_src();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule